// File: doc/BRIEF.md
# Cascadable Prescaled Reload Timer Channel

One 16-bit timer channel that counts upward and wraps from 0xFFFF to zero. Its source of counts is either the system clock passed through a selectable divider, or overflow ticks arriving from a neighbouring channel (chained mode). Two write-only registers set it up: a reload value and a small control byte. The control byte holds a divider select, a chain flag, an interrupt enable and a run enable. Software reads back the live count and the control byte.

The counter takes the reload value in only two cases: when the run enable goes from 0 to 1, and when it wraps in divided-clock mode. In chained mode a wrap leaves the counter at zero. Every wrap produces a single-cycle overflow pulse, which a later channel can use as its chain tick. With the interrupt enable set, a wrap also sets a sticky interrupt level, which stays high until `irq_ack` clears it. There is no streaming data path, so every pin is a plain strobe or level. Register writes are accepted in the cycle their strobe is high and are never stalled.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset the count is 0x0000, the control readback is 0x00, and `ovf_pulse` and `irq` are low.
- R2: The control byte has this layout: bits [1:0] are the divider select, bit 2 is the chain flag, bit 6 is the interrupt enable and bit 7 is the run enable. The readback returns the last written byte with bits 5:3 forced to zero.
- R3: A reload write never changes the count in progress. The new value takes effect at the next run-enable rise or at the next divided-clock wrap.
- R4: A control write that changes run enable from 0 to 1 loads the count from the reload register as it stood before that clock edge. A control write while the channel is already running leaves the count unchanged.
- R5: Divider select 0, 1, 2 and 3 advances the count once every 1, 64, 256 and 1024 clocks. The divider restarts at enable rise and at any change of select, so the first advance comes one full period later.
- R6: While run enable is 0 the count holds its value, whatever `cascade_tick` and the divider do.
- R7: In divided-clock mode, a wrap past 0xFFFF loads the reload value and raises `ovf_pulse` for one cycle, on the same edge.
- R8: In chained mode each `cascade_tick` cycle advances the count by one and the divider has no effect. `cascade_tick` is ignored when the channel is disabled.
- R9: In chained mode a wrap leaves the count at 0x0000 without reloading and raises `ovf_pulse` for one cycle.
- R10: A wrap while the interrupt enable is set drives `irq` high from the same edge, and it stays high until `irq_ack`. A wrap with the interrupt enable clear leaves `irq` low.
- R11: When a wrap and `irq_ack` fall in the same cycle, `irq` ends up high.
- R12: Setting the chain flag while running keeps the count at the value it had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload write data |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| cascade_tick | input | 1 | Overflow tick from the preceding channel |
| irq_ack | input | 1 | Clears the sticky interrupt |
| count_q | output | 16 | Live counter value |
| ctrl_rdata | output | 8 | Control register readback |
| ovf_pulse | output | 1 | One-cycle pulse on every wrap |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two things can happen in the same clock edge: the interrupt is set by a wrap and cleared by an acknowledge. The bench provokes this by loading 0xFFFE with the interrupt enable on in divide-by-1 mode, then holding `irq_ack` high across the exact edge where the count wraps. The check passes only if `irq` is high after that edge. A second case follows the same pattern: a change of divider select falls in the middle of a period. It is judged by the absence of an advance until a full new period has passed from the write edge.

// File: rtl/timer_chan_pkg.sv
`timescale 1ns/1ps
package timer_chan_pkg;
  typedef enum logic [1:0] {
    PS_DIV1    = 2'd0,
    PS_DIV64   = 2'd1,
    PS_DIV256  = 2'd2,
    PS_DIV1024 = 2'd3
  } psel_e;

  localparam int CTRL_PSEL_LSB = 0;
  localparam int CTRL_CHAIN_BIT = 2;
  localparam int CTRL_IE_BIT = 6;
  localparam int CTRL_RUN_BIT = 7;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import timer_chan_pkg::*;
#(
  parameter int DIV1_LOG2 = 6,
  parameter int DIV2_LOG2 = 8,
  parameter int DIV3_LOG2 = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  restart,
  input  psel_e psel,
  output logic  tick
);
  localparam int DIV_W = DIV3_LOG2;
  localparam int LOGS [4] = '{0, DIV1_LOG2, DIV2_LOG2, DIV3_LOG2};

  logic [DIV_W-1:0] lim_tab [4];
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] div_cnt;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tab[g] = DIV_W'((64'd1 << LOGS[g]) - 64'd1);
  end

  assign limit = lim_tab[psel];
  assign tick  = run && (div_cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) div_cnt <= '0;
    else if (run) begin
      if (div_cnt == limit) div_cnt <= '0;
      else                  div_cnt <= div_cnt + 1'b1;
    end
  end

  // R5: the phase never runs past the period of the current select
  assert_div_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= limit);
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             inc,
  input  logic             chain_mode,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             ovf_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap = inc && !load && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      if (load) count <= reload_val;
      else if (inc) begin
        if (count == CNT_MAX) count <= chain_mode ? '0 : reload_val;
        else                  count <= count + 1'b1;
      end
    end
  end

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !inc |=> $stable(count));
  assert_rise_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(reload_val));
  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && count != CNT_MAX |=> count == $past(count) + 1'b1);
  assert_free_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse && !$past(chain_mode) |-> count == $past(reload_val));
  assert_chain_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse && $past(chain_mode) |-> count == '0);
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (ack) irq <= 1'b0;
  end

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);
endmodule

// File: rtl/reload_timer_chan.sv
`timescale 1ns/1ps
module reload_timer_chan
  import timer_chan_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int CTRL_W    = 8,
  parameter int DIV1_LOG2 = 6,
  parameter int DIV2_LOG2 = 8,
  parameter int DIV3_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_we,
  input  logic [CNT_W-1:0]  reload_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              cascade_tick,
  input  logic              irq_ack,
  output logic [CNT_W-1:0]  count_q,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic              ovf_pulse,
  output logic              irq
);
  localparam logic [CTRL_W-1:0] RD_MASK =
    CTRL_W'((1 << CTRL_RUN_BIT) | (1 << CTRL_IE_BIT) | (1 << CTRL_CHAIN_BIT) | (3 << CTRL_PSEL_LSB));

  logic [CNT_W-1:0] reload_q;
  psel_e psel_q, psel_new;
  logic  chain_q, ie_q, run_q;
  logic  en_rise, restart, free_run, pre_tick, inc, wrap;
  logic  ctrl_unused;

  assign ctrl_unused = ^(ctrl_wdata & ~RD_MASK);

  assign psel_new = psel_e'(ctrl_wdata[CTRL_PSEL_LSB +: 2]);
  assign en_rise  = ctrl_we && ctrl_wdata[CTRL_RUN_BIT] && !run_q;
  assign restart  = en_rise || (ctrl_we && (psel_new != psel_q));
  assign free_run = run_q && !chain_q;
  assign inc      = pre_tick || (run_q && chain_q && cascade_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      psel_q   <= PS_DIV1;
      chain_q  <= 1'b0;
      ie_q     <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (reload_we) reload_q <= reload_wdata;
      if (ctrl_we) begin
        psel_q  <= psel_new;
        chain_q <= ctrl_wdata[CTRL_CHAIN_BIT];
        ie_q    <= ctrl_wdata[CTRL_IE_BIT];
        run_q   <= ctrl_wdata[CTRL_RUN_BIT];
      end
    end
  end

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[CTRL_PSEL_LSB +: 2] = psel_q;
    ctrl_rdata[CTRL_CHAIN_BIT]     = chain_q;
    ctrl_rdata[CTRL_IE_BIT]        = ie_q;
    ctrl_rdata[CTRL_RUN_BIT]       = run_q;
  end

  tmr_prescaler #(
    .DIV1_LOG2(DIV1_LOG2), .DIV2_LOG2(DIV2_LOG2), .DIV3_LOG2(DIV3_LOG2)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run(free_run), .restart(restart),
    .psel(psel_q), .tick(pre_tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(en_rise), .reload_val(reload_q),
    .inc(inc), .chain_mode(chain_q), .count(count_q), .wrap(wrap),
    .ovf_pulse(ovf_pulse)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(wrap && ie_q), .ack(irq_ack), .irq(irq)
  );

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_rdata == ($past(ctrl_wdata) & RD_MASK));
  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !en_rise |=> $stable(count_q));
endmodule

// File: tb/reload_timer_chan_test.sv
`timescale 1ns/1ps
module reload_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reload_we = 1'b0;
  logic [15:0] reload_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic        cascade_tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic [15:0] count_q;
  logic [7:0]  ctrl_rdata;
  logic        ovf_pulse;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  reload_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .reload_we(reload_we), .reload_wdata(reload_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .cascade_tick(cascade_tick),
    .irq_ack(irq_ack), .count_q(count_q), .ctrl_rdata(ctrl_rdata),
    .ovf_pulse(ovf_pulse), .irq(irq)
  );

  // {select[3:0], reload[15:0], clocks after enable[11:0], expected count[15:0]}
  localparam logic [47:0] VEC [8] = '{
    {4'd0, 16'h0010, 12'd5,    16'h0015},
    {4'd1, 16'h0100, 12'd63,   16'h0100},
    {4'd1, 16'h0100, 12'd64,   16'h0101},
    {4'd2, 16'h2000, 12'd255,  16'h2000},
    {4'd2, 16'h2000, 12'd512,  16'h2002},
    {4'd3, 16'h7FF0, 12'd1023, 16'h7FF0},
    {4'd3, 16'h7FF0, 12'd2048, 16'h7FF2},
    {4'd0, 16'hFFF0, 12'd15,   16'hFFFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_wdata = d; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_reload(input logic [15:0] d);
    reload_wdata = d; reload_we = 1'b1;
    @(negedge clk);
    reload_we = 1'b0;
  endtask

  task automatic chain_tick();
    cascade_tick = 1'b1;
    @(negedge clk);
    cascade_tick = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check("R1 count", count_q, 16'h0000);
    check("R1 ctrl", {8'h00, ctrl_rdata}, 16'h0000);
    check("R1 ovf/irq", {14'd0, ovf_pulse, irq}, 16'h0000);

    // R5 divider encodings, table driven
    foreach (VEC[i]) begin
      wr_reload(VEC[i][43:28]);
      wr_ctrl(8'h80 | {6'd0, VEC[i][45:44]});
      step(int'(VEC[i][27:16]));
      check($sformatf("R5 vec%0d", i), count_q, VEC[i][15:0]);
      wr_ctrl(8'h00);
    end

    // R2 readback masking
    wr_ctrl(8'hFF);
    check("R2 all ones", {8'h00, ctrl_rdata}, 16'h00C7);
    wr_ctrl(8'h00);
    check("R2 cleared", {8'h00, ctrl_rdata}, 16'h0000);

    // R3 / R4 reload timing
    wr_reload(16'h1000);
    wr_ctrl(8'h83);
    wr_reload(16'h2222);
    step(5);
    check("R3 reload write no effect", count_q, 16'h1000);
    wr_ctrl(8'h83);
    check("R4 rewrite while running", count_q, 16'h1000);
    wr_ctrl(8'h00);
    wr_ctrl(8'h83);
    check("R4 rise loads new reload", count_q, 16'h2222);
    wr_ctrl(8'h00);

    // R6 hold while disabled
    wr_reload(16'h0100);
    wr_ctrl(8'h80);
    step(10);
    check("R6 running", count_q, 16'h010A);
    wr_ctrl(8'h00);
    step(20);
    chain_tick();
    check("R6 hold", count_q, 16'h010B);

    // R5 divider restart on select change mid-period
    wr_reload(16'h0000);
    wr_ctrl(8'h81);
    step(39);
    wr_ctrl(8'h82);
    step(255);
    check("R5 restart no early step", count_q, 16'h0000);
    step(1);
    check("R5 restart full period", count_q, 16'h0001);
    wr_ctrl(8'h00);

    // R7 / R10 free-running wrap with interrupt
    wr_reload(16'hFFFD);
    wr_ctrl(8'hC0);
    step(2);
    check("R7 at max", {ovf_pulse, 15'd0} | 16'h0, 16'h0000);
    check("R7 count max", count_q, 16'hFFFF);
    step(1);
    check("R7 reloaded", count_q, 16'hFFFD);
    check("R7 pulse high", {15'd0, ovf_pulse}, 16'h0001);
    check("R10 irq set", {15'd0, irq}, 16'h0001);
    step(1);
    check("R7 pulse one cycle", {15'd0, ovf_pulse}, 16'h0000);
    wr_ctrl(8'h00);
    step(5);
    check("R10 irq sticky", {15'd0, irq}, 16'h0001);
    ack();
    check("R10 irq cleared", {15'd0, irq}, 16'h0000);

    // R10 no interrupt when disabled
    wr_reload(16'hFFFF);
    wr_ctrl(8'h80);
    step(1);
    check("R10 wrap pulse", {15'd0, ovf_pulse}, 16'h0001);
    check("R10 no irq", {15'd0, irq}, 16'h0000);
    wr_ctrl(8'h00);

    // R11 wrap and acknowledge on the same edge
    wr_reload(16'hFFFE);
    wr_ctrl(8'hC0);
    step(1);
    ack();
    check("R11 set beats ack", {15'd0, irq}, 16'h0001);
    wr_ctrl(8'h00);
    ack();
    check("R11 later ack", {15'd0, irq}, 16'h0000);

    // R12 / R8 chained mode
    wr_reload(16'h0005);
    wr_ctrl(8'h80);
    step(3);
    wr_ctrl(8'h84);
    check("R12 hold on chain switch", count_q, 16'h0009);
    step(10);
    check("R8 divider ignored", count_q, 16'h0009);
    chain_tick(); chain_tick(); chain_tick();
    check("R8 chain ticks", count_q, 16'h000C);
    wr_ctrl(8'h04);
    chain_tick(); chain_tick();
    check("R8 ticks ignored disabled", count_q, 16'h000C);

    // R9 chained wrap goes to zero
    wr_reload(16'hFFFE);
    wr_ctrl(8'hC4);
    chain_tick();
    check("R9 before wrap", count_q, 16'hFFFF);
    chain_tick();
    check("R9 wrap to zero", count_q, 16'h0000);
    check("R9 pulse", {15'd0, ovf_pulse}, 16'h0001);
    check("R9 irq", {15'd0, irq}, 16'h0001);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule